// File: doc/BRIEF.md
# Row-Granular Fully Associative Cache

This block sits between a sparse-matrix elimination pipeline and external memory. Each cache line holds one complete compressed matrix row: a sequence of packed column-index/value words plus a length. Lines are found by row number through a content-addressable compare against every valid line. The pipeline can fetch one element of a row, stream a whole row at one word per cycle, or rewrite a whole row.

A lookup that misses takes a line chosen in FIFO order and fetches the row from memory. Lines flagged as in-process by the lock interface are never chosen. If the chosen line holds modified data, that row is first streamed back to memory, because the cache is write-back. Only a row that is resident and locked is rewritten, so a row write never misses. If every line is locked, the miss waits until a lock is released.

Top module: `rowcache_top`

## Requirements
- R1: A request for a row that is resident is served with no memory fetch. A request for a row that is not resident causes exactly one `memRdReq` pulse carrying that row number. No row is ever resident in two lines at once.
- R2: On a hit, the first response word appears with `rspValid` high two clock edges after the edge that accepted the request.
- R3: Request op encoding: 0 is a single-word read, 1 is a whole-row read and 2 is a whole-row write. A whole-row read returns every word of the row in index order, in back-to-back cycles, with `rspLast` set only on the final word. A single-word read returns the one word at `reqIdx`, with `rspLast` set.
- R4: On a miss, `busy` is high in the cycle after acceptance and stays high until the fill finishes. The fetched words are then returned as in R3.
- R5: When the line being replaced holds a row that has been written, that row is streamed out on `memWr*`, all its words, before the fetch request. A clean line is dropped with no `memWr*` traffic. A later miss on the written row returns the written data.
- R6: The replacement order is FIFO over lines. A line whose row is locked with `lockSet` is skipped and stays resident until `lockClr` is given for that row.
- R7: If every line is locked when a miss occurs, the block holds with `reqReady` low, `busy` high and no memory request until a lock is released. It then completes the request.
- R8: A fetched row longer than `MAX_LEN` words gives a one-cycle `lenErr` pulse. The line keeps the first `MAX_LEN` words and reports that length.
- R9: A whole-row write to a locked resident row accepts words on `wrValid && wrReady` until `wrLast`. It replaces the line's contents and length without any memory traffic, and later reads return the new data.
- R10: After reset, `reqReady` is high and `busy`, `rspValid`, `wrReady`, `lenErr`, `memRdReq` and `memWrValid` are low. No row is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge when both are high |
| reqOp | input | 2 | 0 word read, 1 row read, 2 row write |
| reqRow | input | ROW_W | Row number |
| reqIdx | input | IDX_W | Word index for a single-word read |
| wrValid | input | 1 | Write word present |
| wrReady | output | 1 | Write word taken when both are high |
| wrData | input | WORD_W | Write word |
| wrLast | input | 1 | Final word of the row write |
| rspValid | output | 1 | Response word valid |
| rspData | output | WORD_W | Response word |
| rspLast | output | 1 | Final response word |
| busy | output | 1 | Miss handling in progress |
| lenErr | output | 1 | Fetched row exceeded line capacity |
| lockSet | input | 1 | Mark resident row `lockRow` in-process |
| lockClr | input | 1 | Release row `lockRow` |
| lockRow | input | ROW_W | Row number for lock operations |
| memRdReq | output | 1 | Row fetch request pulse |
| memRdRow | output | ROW_W | Row number to fetch |
| memRvalid | input | 1 | Fetched word valid |
| memRdata | input | WORD_W | Fetched word |
| memRlast | input | 1 | Final fetched word |
| memWrValid | output | 1 | Write-back word valid |
| memWrRow | output | ROW_W | Row number being written back |
| memWrData | output | WORD_W | Write-back word |
| memWrLast | output | 1 | Final write-back word |

## Verification
The bench builds the block with four lines of eight words each. With so few lines, a dozen distinct rows keep replacement busy, so dirty evictions, locked-line skipping and FIFO wraparound all occur many times. Because eight words is short, a seeded over-long row reaches the capacity flag. A small line count also lets the bench lock every line and force the stall.

// File: rtl/rowcache_pkg.sv
package rowcache_pkg;
  typedef enum logic [1:0] {OP_WORD = 2'd0, OP_ROW = 2'd1, OP_WRITE = 2'd2} op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_REQ, S_FILL, S_SEND, S_WRITE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic latchHit;
    logic latchVictim;
    logic wbStep;
    logic fillStep;
    logic fillCommit;
    logic wrStep;
    logic wrCommit;
    logic sendStep;
  } ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic victimOk;
    logic victimDirty;
    logic wbLast;
    logic sendLast;
    logic opWrite;
  } sts_t;
endpackage

// File: rtl/rowcache_ctrl.sv
module rowcache_ctrl
  import rowcache_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic wrValid,
  input  logic wrLast,
  input  logic memRvalid,
  input  logic memRlast,
  input  sts_t sts,
  output ctl_t ctl,
  output logic reqReady,
  output logic wrReady,
  output logic busy,
  output logic memRdReq
);
  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        nextState = S_LOOK;
      end
      S_LOOK: begin
        if (sts.hit) begin
          ctl.latchHit = 1'b1;
          nextState = sts.opWrite ? S_WRITE : S_SEND;
        end else if (sts.victimOk) begin
          ctl.latchVictim = 1'b1;
          nextState = sts.victimDirty ? S_WB : S_REQ;
        end
      end
      S_WB: begin
        ctl.wbStep = 1'b1;
        if (sts.wbLast) nextState = S_REQ;
      end
      S_REQ: nextState = S_FILL;
      S_FILL: if (memRvalid) begin
        ctl.fillStep = 1'b1;
        if (memRlast) begin
          ctl.fillCommit = 1'b1;
          nextState = sts.opWrite ? S_WRITE : S_SEND;
        end
      end
      S_SEND: begin
        ctl.sendStep = 1'b1;
        if (sts.sendLast) nextState = S_IDLE;
      end
      S_WRITE: if (wrValid) begin
        ctl.wrStep = 1'b1;
        if (wrLast) begin
          ctl.wrCommit = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign wrReady  = (state == S_WRITE);
  assign memRdReq = (state == S_REQ);
  assign busy = (state == S_WB) || (state == S_REQ) || (state == S_FILL) ||
                ((state == S_LOOK) && !sts.hit);

  // R9: a row write only ever targets a resident line
  p_write_hits_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LOOK && sts.opWrite) |-> sts.hit);

  // R4: memory only answers while a miss is being handled
  p_fill_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRvalid |-> busy);
endmodule

// File: rtl/rowcache_dp.sv
module rowcache_dp
  import rowcache_pkg::*;
#(
  parameter int LINES   = 4,
  parameter int MAX_LEN = 8,
  parameter int ROW_W   = 8,
  parameter int WORD_W  = 32,
  localparam int LINE_W = $clog2(LINES),
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  output sts_t              sts,
  input  logic [1:0]        reqOp,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              lockSet,
  input  logic              lockClr,
  input  logic [ROW_W-1:0]  lockRow,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              rspLast,
  output logic              lenErr,
  output logic [ROW_W-1:0]  memRdRow,
  output logic              memWrValid,
  output logic [ROW_W-1:0]  memWrRow,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWrLast
);
  logic [ROW_W-1:0]  tagArr  [LINES];
  logic [CNT_W-1:0]  lenArr  [LINES];
  logic [WORD_W-1:0] dataArr [LINES][MAX_LEN];
  logic [LINES-1:0]  validArr, dirtyArr, lockArr, hitVec, lockVec;
  logic [LINE_W-1:0] fifoPtr, line, hitIdx, victim;
  logic [ROW_W-1:0]  curRow;
  logic [IDX_W-1:0]  curIdx, rdSel;
  logic [1:0]        curOp;
  logic [CNT_W-1:0]  cnt, curLenM1, lenFinal;
  logic              over, atCap, victimOk;

  // content-addressable compare, one comparator per line
  for (genvar g = 0; g < LINES; g++) begin : g_cam
    assign hitVec[g]  = validArr[g] && (tagArr[g] == curRow);
    assign lockVec[g] = validArr[g] && (tagArr[g] == lockRow);
  end

  always_comb begin
    hitIdx = '0;
    for (int k = 0; k < LINES; k++)
      if (hitVec[k]) hitIdx = LINE_W'(k);
  end

  // FIFO victim: first line from fifoPtr onward that is not locked
  always_comb begin
    victimOk = 1'b0;
    victim   = fifoPtr;
    for (int k = 0; k < LINES; k++) begin
      int idx;
      idx = (int'(fifoPtr) + k) % LINES;
      if (!victimOk && !(validArr[idx] && lockArr[idx])) begin
        victimOk = 1'b1;
        victim   = LINE_W'(idx);
      end
    end
  end

  assign curLenM1 = lenArr[line] - CNT_W'(1);
  assign atCap    = (cnt == CNT_W'(MAX_LEN));
  assign lenFinal = atCap ? CNT_W'(MAX_LEN) : cnt + CNT_W'(1);
  assign rdSel    = (curOp == OP_WORD) ? curIdx : cnt[IDX_W-1:0];

  assign sts.hit         = |hitVec;
  assign sts.victimOk    = victimOk;
  assign sts.victimDirty = validArr[victim] && dirtyArr[victim];
  assign sts.wbLast      = (cnt == curLenM1);
  assign sts.sendLast    = (curOp == OP_WORD) || (cnt == curLenM1);
  assign sts.opWrite     = (curOp == OP_WRITE);

  assign memRdRow   = curRow;
  assign memWrValid = ctl.wbStep;
  assign memWrRow   = tagArr[line];
  assign memWrData  = dataArr[line][cnt[IDX_W-1:0]];
  assign memWrLast  = sts.wbLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
      lockArr  <= '0;
      fifoPtr  <= '0;
      line     <= '0;
      cnt      <= '0;
      over     <= 1'b0;
      curRow   <= '0;
      curIdx   <= '0;
      curOp    <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      rspLast  <= 1'b0;
      lenErr   <= 1'b0;
    end else begin
      rspValid <= ctl.sendStep;
      lenErr   <= 1'b0;
      for (int k = 0; k < LINES; k++) begin
        if (lockVec[k] && lockSet) lockArr[k] <= 1'b1;
        if (lockVec[k] && lockClr) lockArr[k] <= 1'b0;
      end
      if (ctl.capture) begin
        curRow <= reqRow;
        curIdx <= reqIdx;
        curOp  <= reqOp;
      end
      if (ctl.latchHit) begin
        line <= hitIdx;
        cnt  <= '0;
      end
      if (ctl.latchVictim) begin
        line             <= victim;
        cnt              <= '0;
        validArr[victim] <= 1'b0;
        lockArr[victim]  <= 1'b0;
      end
      if (ctl.wbStep) cnt <= sts.wbLast ? '0 : cnt + CNT_W'(1);
      if (ctl.fillStep || ctl.wrStep) begin
        if (ctl.fillCommit || ctl.wrCommit) begin
          lenErr <= over || atCap;
          cnt    <= '0;
          over   <= 1'b0;
        end else begin
          cnt  <= atCap ? cnt : cnt + CNT_W'(1);
          over <= over || atCap;
        end
      end
      if (ctl.fillCommit) begin
        validArr[line] <= 1'b1;
        dirtyArr[line] <= 1'b0;
        fifoPtr        <= LINE_W'((int'(line) + 1) % LINES);
      end
      if (ctl.wrCommit) dirtyArr[line] <= 1'b1;
      if (ctl.sendStep) begin
        rspData <= dataArr[line][rdSel];
        rspLast <= sts.sendLast;
        cnt     <= cnt + CNT_W'(1);
      end
    end
  end

  // line storage: no reset, on-chip arrays
  always_ff @(posedge clk) begin
    if ((ctl.fillStep || ctl.wrStep) && !atCap)
      dataArr[line][cnt[IDX_W-1:0]] <= ctl.fillStep ? memRdata : wrData;
    if (ctl.fillCommit) begin
      tagArr[line] <= curRow;
      lenArr[line] <= lenFinal;
    end
    if (ctl.wrCommit) lenArr[line] <= lenFinal;
  end

  // R1: a row number never matches two lines
  p_cam_unique_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R3: a row burst has no gaps until its last word
  p_burst_gapless_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspLast) |=> rspValid);

  // R5: only a modified line is streamed back
  p_wb_dirty_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> dirtyArr[line]);

  // R6: a locked line stays resident while its lock holds
  for (genvar g = 0; g < LINES; g++) begin : g_lockchk
    p_locked_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
      (validArr[g] && lockArr[g] && !lockClr) |=> validArr[g]);
  end
endmodule

// File: rtl/rowcache_top.sv
module rowcache_top
  import rowcache_pkg::*;
#(
  parameter int LINES   = 4,
  parameter int MAX_LEN = 8,
  parameter int ROW_W   = 8,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrLast,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              rspLast,
  output logic              busy,
  output logic              lenErr,
  input  logic              lockSet,
  input  logic              lockClr,
  input  logic [ROW_W-1:0]  lockRow,
  output logic              memRdReq,
  output logic [ROW_W-1:0]  memRdRow,
  input  logic              memRvalid,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memRlast,
  output logic              memWrValid,
  output logic [ROW_W-1:0]  memWrRow,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWrLast
);
  ctl_t ctl;
  sts_t sts;

  rowcache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrValid(wrValid),
    .wrLast(wrLast), .memRvalid(memRvalid), .memRlast(memRlast),
    .sts(sts), .ctl(ctl), .reqReady(reqReady), .wrReady(wrReady),
    .busy(busy), .memRdReq(memRdReq)
  );

  rowcache_dp #(
    .LINES(LINES), .MAX_LEN(MAX_LEN), .ROW_W(ROW_W), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sts(sts), .reqOp(reqOp),
    .reqRow(reqRow), .reqIdx(reqIdx), .wrData(wrData), .memRdata(memRdata),
    .lockSet(lockSet), .lockClr(lockClr), .lockRow(lockRow),
    .rspValid(rspValid), .rspData(rspData), .rspLast(rspLast),
    .lenErr(lenErr), .memRdRow(memRdRow), .memWrValid(memWrValid),
    .memWrRow(memWrRow), .memWrData(memWrData), .memWrLast(memWrLast)
  );
endmodule

// File: tb/rowcache_top_bench.sv
module rowcache_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4, MAX_LEN = 8, ROW_W = 8, WORD_W = 32, IDX_W = 3;

  logic clk, rstN, reqValid, reqReady, wrValid, wrReady, wrLast;
  logic [1:0] reqOp;
  logic [ROW_W-1:0] reqRow, lockRow, memRdRow, memWrRow;
  logic [IDX_W-1:0] reqIdx;
  logic [WORD_W-1:0] wrData, rspData, memRdata, memWrData;
  logic rspValid, rspLast, busy, lenErr, lockSet, lockClr;
  logic memRdReq, memRvalid, memRlast, memWrValid, memWrLast;

  rowcache_top #(.LINES(LINES), .MAX_LEN(MAX_LEN), .ROW_W(ROW_W), .WORD_W(WORD_W))
    u_rowcache_top (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int tests = 0, fails = 0, rowHits = 0, rowMisses = 0;
  int rdReqCnt = 0, wbBeats = 0, lenErrCnt = 0, wbIdx = 0;
  logic [WORD_W-1:0] refData [16][16];
  logic [WORD_W-1:0] memData [16][16];
  int refLen [16];
  int memLen [16];
  int  mRow [LINES];
  bit  mValid [LINES], mDirty [LINES], mLock [LINES];
  int  mPtr = 0;
  bit  mrBusy = 0;
  int  mrRow = 0, mrIdx = 0, mrDelay = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int effLen(input int row);
    return (refLen[row] > MAX_LEN) ? MAX_LEN : refLen[row];
  endfunction

  function automatic int mFind(input int row);
    for (int l = 0; l < LINES; l++) if (mValid[l] && mRow[l] == row) return l;
    return -1;
  endfunction

  function automatic int mVictim();
    for (int k = 0; k < LINES; k++) begin
      int l;
      l = (mPtr + k) % LINES;
      if (!(mValid[l] && mLock[l])) return l;
    end
    return 0;
  endfunction

  // external memory model and monitors
  always @(negedge clk) begin
    memRvalid = 1'b0;
    memRlast  = 1'b0;
    if (rstN && lenErr) lenErrCnt++;
    if (rstN && memWrValid) begin
      memData[memWrRow][wbIdx] = memWrData;
      wbIdx++;
      wbBeats++;
      if (memWrLast) begin
        memLen[memWrRow] = wbIdx;
        wbIdx = 0;
      end
    end
    if (mrBusy) begin
      if (mrDelay > 0) mrDelay--;
      else begin
        memRvalid = 1'b1;
        memRdata  = memData[mrRow][mrIdx];
        memRlast  = (mrIdx == memLen[mrRow] - 1);
        if (memRlast) mrBusy = 0;
        mrIdx++;
      end
    end
    if (rstN && memRdReq) begin
      rdReqCnt++;
      mrBusy = 1; mrRow = int'(memRdRow); mrIdx = 0; mrDelay = 1;
    end
  end

  task automatic lockOp(input int row, input bit set);
    int l;
    @(negedge clk);
    lockRow = row[ROW_W-1:0]; lockSet = set; lockClr = !set;
    @(negedge clk);
    lockSet = 1'b0; lockClr = 1'b0;
    l = mFind(row);
    if (l >= 0) mLock[l] = set;
  endtask

  // op: 0 word read, 1 row read, 2 row write
  task automatic doReq(input int op, input int row, input int idx, input int wlen);
    int ln, v, rd0, wb0, cyc, got, first, expWords, k, expWb;
    logic [WORD_W-1:0] exp;
    bit hitExp;
    ln = mFind(row); hitExp = (ln >= 0); rd0 = rdReqCnt; wb0 = wbBeats;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op[1:0]; reqRow = row[ROW_W-1:0]; reqIdx = idx[IDX_W-1:0];
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    check(busy == !hitExp, "R4", int'(busy), int'(!hitExp), "busy after lookup");
    if (op != 2) begin
      expWords = (op == 0) ? 1 : effLen(row);
      got = 0; first = 0;
      while (got < expWords) begin
        if (rspValid) begin
          if (first == 0) first = cyc;
          exp = (op == 0) ? refData[row][idx] : refData[row][got];
          check(rspData == exp, hitExp ? "R3" : "R4", int'(rspData), int'(exp), "read word");
          check(rspLast == (got == expWords - 1), "R3", int'(rspLast),
                int'(got == expWords - 1), "last flag");
          got++;
        end
        @(negedge clk);
        cyc++;
      end
      check(!rspValid, "R3", int'(rspValid), 0, "burst ends");
      // two edges after acceptance is the third negedge counted here
      if (hitExp) check(first == 3, "R2", first, 3, "hit latency");
    end else begin
      for (int i = 0; i < wlen; i++)
        refData[row][i] = {row[7:0], i[7:0], 16'($urandom)};
      refLen[row] = wlen;
      k = 0;
      while (k < wlen) begin
        if (wrReady) begin
          wrValid = 1'b1; wrData = refData[row][k]; wrLast = (k == wlen - 1);
          k++;
        end else wrValid = 1'b0;
        @(negedge clk);
      end
      wrValid = 1'b0; wrLast = 1'b0;
      check(wbBeats == wb0, "R9", wbBeats - wb0, 0, "write memory traffic");
    end
    check((rdReqCnt - rd0) == (hitExp ? 0 : 1), "R1", rdReqCnt - rd0, hitExp ? 0 : 1,
          "row fetches");
    if (hitExp) rowHits++;
    else begin
      rowMisses++;
      v = mVictim();
      expWb = (mValid[v] && mDirty[v]) ? effLen(mRow[v]) : 0;
      check((wbBeats - wb0) == expWb, "R5", wbBeats - wb0, expWb, "write-back beats");
      mRow[v] = row; mValid[v] = 1; mDirty[v] = 0; mLock[v] = 0;
      mPtr = (v + 1) % LINES;
      ln = v;
    end
    if (op == 2) mDirty[ln] = 1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r0, lc, r, row, l;
    int locked [LINES];
    void'($urandom(32'd1234));
    rstN = 1'b0; reqValid = 0; reqOp = 0; reqRow = 0; reqIdx = 0;
    wrValid = 0; wrData = 0; wrLast = 0; lockSet = 0; lockClr = 0; lockRow = 0;
    memRvalid = 0; memRdata = 0; memRlast = 0;
    for (int i = 0; i < 16; i++) begin
      refLen[i] = (i == 13) ? 11 : 1 + (i % 8);
      memLen[i] = refLen[i];
      for (int j = 0; j < 16; j++) begin
        refData[i][j] = {i[7:0], j[7:0], 16'hC000 + 16'(j)};
        memData[i][j] = refData[i][j];
      end
    end
    for (int i = 0; i < LINES; i++) begin mValid[i] = 0; mDirty[i] = 0; mLock[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(reqReady == 1, "R10", int'(reqReady), 1, "reqReady");
    check(busy == 0 && rspValid == 0 && wrReady == 0, "R10", int'({busy, rspValid, wrReady}), 0, "idle flags");
    check(lenErr == 0 && memRdReq == 0 && memWrValid == 0, "R10",
          int'({lenErr, memRdReq, memWrValid}), 0, "memory side idle");

    // fill four lines, then hits (R1, R2, R3, R4)
    for (int i = 0; i < 4; i++) doReq(1, i, 0, 0);
    doReq(1, 1, 0, 0);
    doReq(0, 2, 1, 0);
    doReq(0, 3, 3, 0);

    // R6: oldest line locked, next line replaced instead
    lockOp(0, 1);
    doReq(1, 4, 0, 0);
    r0 = rdReqCnt;
    doReq(1, 0, 0, 0);
    check(rdReqCnt == r0, "R6", rdReqCnt - r0, 0, "locked row kept");
    lockOp(0, 0);

    // R9 write to locked resident row, then R5 eviction of it
    lockOp(2, 1);
    doReq(2, 2, 0, 5);
    lockOp(2, 0);
    doReq(1, 2, 0, 0);
    doReq(1, 5, 0, 0);
    r0 = rdReqCnt;
    doReq(1, 2, 0, 0);
    check(rdReqCnt == r0 + 1, "R5", rdReqCnt - r0, 1, "written row refetched");

    // R8 over-long row
    lc = lenErrCnt;
    doReq(1, 13, 0, 0);
    check(lenErrCnt == lc + 1, "R8", lenErrCnt - lc, 1, "lenErr pulse");
    doReq(1, 13, 0, 0);
    doReq(0, 13, 7, 0);

    // R7 every line locked
    for (int i = 0; i < LINES; i++) locked[i] = mRow[i];
    for (int i = 0; i < LINES; i++) lockOp(locked[i], 1);
    r0 = rdReqCnt;
    fork
      doReq(1, 9, 0, 0);
      begin
        repeat (6) @(negedge clk);
        check(reqReady == 0, "R7", int'(reqReady), 0, "stall reqReady");
        check(busy == 1, "R7", int'(busy), 1, "stall busy");
        check(rdReqCnt == r0, "R7", rdReqCnt - r0, 0, "no fetch while stalled");
        lockOp(locked[2], 0);
      end
    join
    for (int i = 0; i < LINES; i++) if (i != 2) lockOp(locked[i], 0);

    // constrained random mix
    for (int n = 0; n < 150; n++) begin
      r = $urandom % 4;
      row = $urandom % 12;
      if (r == 0) doReq(0, row, $urandom % effLen(row), 0);
      else if (r == 3) begin
        l = $urandom % LINES;
        if (mValid[l]) begin
          row = mRow[l];
          lockOp(row, 1);
          doReq(2, row, 0, 1 + ($urandom % MAX_LEN));
          lockOp(row, 0);
        end
      end else doReq(1, row, 0, 0);
    end

    $display("row hits %0d, row misses %0d", rowHits, rowMisses);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule